// File: doc/BRIEF.md
# Sticky Flash Status Register

This block holds the eight-bit status byte that a flash write engine keeps for its program and erase operations. The engine drives set and clear strobes, one bit per status position. The bits that report progress are the ready flag and the two suspend flags, and the engine may lower them again. The bits that report failures are sticky. Once raised, a failure bit stays up until a Clear Status command strobe or a reset removes it. Host software can therefore run several operations back to back and look for an error once, at the end.

A host read is a cycle in which chip enable and output enable are both sampled low. The byte shown for that read is captured on the first such cycle, which is the cycle of whichever enable fell last. The byte then holds still for as long as both enables stay low, even if the live status changes. To see a newer value, the host must raise one of the enables and lower it again. While a read is in progress, the lower data lanes carry the captured byte and the upper lanes carry zero. When no read is in progress, the whole data output is driven to zero.

Top module: `flash_status_reg`

## Requirements
- R1: Reset is synchronous and active high. After reset the status is 80h. Bit positions are: ready 7, erase suspended 6, erase error 5, program error 4, supply-low abort 3, program suspended 2, locked-sector abort 1, reserved 0.
- R2: Bit 0 always reads 0. An engine set strobe on bit 0 has no effect.
- R3: An engine clear strobe lowers only bits 7, 6 and 2. An engine clear strobe on bits 5, 4, 3, 1 or 0 has no effect.
- R4: Bits 5, 4, 3 and 1 stay set across later engine activity, so errors from several operations accumulate.
- R5: The clear-command strobe lowers bits 5, 4, 3 and 1 and leaves bits 7, 6 and 2 unchanged.
- R6: If a set strobe hits a bit in the same cycle as any clear (an engine clear or the clear command), the bit ends up set.
- R7: The sequence-error strobe sets bits 5, 4, 3 and 1 together.
- R8: The captured byte is the status as it stood just before the first clock edge at which both enables are sampled low. It appears on dout after that edge and is held while both enables stay low.
- R9: While a read is in progress, dout[15:8] is 00h. When either enable is sampled high, all of dout is 0.
- R10: A status change becomes visible only after an enable has been raised and lowered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_set | input | 8 | Engine set strobes, one per status bit |
| eng_clr | input | 8 | Engine clear strobes, one per status bit (only bits 7, 6 and 2 honoured) |
| seq_err | input | 1 | Command sequence error strobe |
| clr_cmd | input | 1 | Clear Status command strobe |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data: captured byte on the low lanes, zeros above |

## Verification
The engine strobes are applied in several patterns. Set alone shows that the bit mapping is correct. Clear on every lane separates the progress bits from the sticky bits. Set together with either kind of clear shows which one takes priority. The sequence-error strobe is checked for its four-bit pattern. Reads are tried with the enables falling in either order and with status changing in the middle of a held read. These read patterns distinguish a snapshot that is captured once from a live view of the status, and show that an enable toggle is needed before new status appears.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int ST_W = 8;

    typedef struct packed {
        logic ready;
        logic ers_susp;
        logic ers_err;
        logic prg_err;
        logic vpp_low;
        logic prg_susp;
        logic lock_abort;
        logic rsvd;
    } fsr_stat_t;

    localparam logic [ST_W-1:0] RESET_VAL    = 8'h80;
    localparam logic [ST_W-1:0] ERR_MASK     = 8'h3A;
    localparam logic [ST_W-1:0] ENG_CLR_MASK = 8'hC4;
    localparam logic [ST_W-1:0] SET_MASK     = 8'hFE;

    typedef enum logic [1:0] {
        BIT_RSVD,
        BIT_PROGRESS,
        BIT_STICKY
    } bit_kind_e;

    function automatic bit_kind_e kind_of(input int idx);
        if (ERR_MASK[idx])
            return BIT_STICKY;
        else if (ENG_CLR_MASK[idx])
            return BIT_PROGRESS;
        else if (SET_MASK[idx])
            return BIT_PROGRESS;
        return BIT_RSVD;
    endfunction

endpackage

// File: rtl/fsr_bits.sv
module fsr_bits
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] eng_set,
    input  logic [ST_W-1:0] eng_clr,
    input  logic            seq_err,
    input  logic            clr_cmd,
    output fsr_stat_t       status
);

    logic [ST_W-1:0] st_q;

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        localparam bit_kind_e KIND = kind_of(i);
        if (KIND == BIT_RSVD) begin : g_rsvd
            always_ff @(posedge clk) begin
                st_q[i] <= 1'b0;
            end
        end else if (KIND == BIT_STICKY) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)
                    st_q[i] <= RESET_VAL[i];
                else if (eng_set[i] || seq_err)
                    st_q[i] <= 1'b1;
                else if (clr_cmd)
                    st_q[i] <= 1'b0;
            end
        end else begin : g_prog
            localparam logic CAN_CLR = ENG_CLR_MASK[i];
            always_ff @(posedge clk) begin
                if (rst)
                    st_q[i] <= RESET_VAL[i];
                else if (eng_set[i])
                    st_q[i] <= 1'b1;
                else if (CAN_CLR && eng_clr[i])
                    st_q[i] <= 1'b0;
            end
        end
    end

    assign status = fsr_stat_t'(st_q);

endmodule

// File: rtl/fsr_snap.sv
module fsr_snap
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce_n,
    input  logic      oe_n,
    input  fsr_stat_t live,
    output fsr_stat_t snap,
    output logic      rd_act
);

    logic      rd_now;
    logic      rd_q;
    fsr_stat_t snap_q;

    assign rd_now = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            snap_q <= fsr_stat_t'(RESET_VAL);
        end else begin
            rd_q <= rd_now;
            if (rd_now && !rd_q)
                snap_q <= live;
        end
    end

    assign snap   = snap_q;
    assign rd_act = rd_q;

endmodule

// File: rtl/fsr_lanes.sv
module fsr_lanes
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fsr_stat_t         snap,
    input  logic              rd_act,
    output logic [DATA_W-1:0] dout
);

    localparam int HI_W = DATA_W - ST_W;

    logic [ST_W-1:0] lo;

    assign lo = rd_act ? ST_W'(snap) : '0;

    if (HI_W > 0) begin : g_pad
        assign dout = {{HI_W{1'b0}}, lo};
    end else begin : g_nopad
        assign dout = lo[DATA_W-1:0];
    end

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        eng_set,
    input  logic [7:0]        eng_clr,
    input  logic              seq_err,
    input  logic              clr_cmd,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout
);

    fsr_stat_t live;
    fsr_stat_t snap;
    logic      rd_act;

    fsr_bits u_bits (
        .clk     (clk),
        .rst     (rst),
        .eng_set (eng_set),
        .eng_clr (eng_clr),
        .seq_err (seq_err),
        .clr_cmd (clr_cmd),
        .status  (live)
    );

    fsr_snap u_snap (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .live   (live),
        .snap   (snap),
        .rd_act (rd_act)
    );

    fsr_lanes #(.DATA_W(DATA_W)) u_lanes (
        .snap   (snap),
        .rd_act (rd_act),
        .dout   (dout)
    );

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        eng_set,
    input logic [7:0]        eng_clr,
    input logic              seq_err,
    input logic              clr_cmd,
    input logic              ce_n,
    input logic              oe_n,
    input logic [7:0]        live,
    input logic [DATA_W-1:0] dout
);

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        live[0] == 1'b0);

    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_cmd |=> (($past(live) & ERR_MASK & ~live) == 8'h00));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|(eng_set & SET_MASK)) |=> ((live & $past(eng_set) & SET_MASK) == ($past(eng_set) & SET_MASK)));

    a_r7_seq_err: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> ((live & ERR_MASK) == ERR_MASK));

    a_r8_held: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && $past(!ce_n && !oe_n)) |=> $stable(dout));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> (dout == '0));

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (dout >> 8) == '0);

endmodule

bind flash_status_reg fsr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .eng_set (eng_set),
    .eng_clr (eng_clr),
    .seq_err (seq_err),
    .clr_cmd (clr_cmd),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .live    (live),
    .dout    (dout)
);

// File: tb/sim_flash_status_reg.sv
`timescale 1ns/1ps
module sim_flash_status_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  eng_set = '0;
    logic [7:0]  eng_clr = '0;
    logic        seq_err = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_st   = 8'h80;
    int m_snap = 8'h80;
    bit m_rd   = 0;

    always #4 clk = ~clk;

    flash_status_reg #(.DATA_W(16)) u0 (
        .clk(clk), .rst(rst), .eng_set(eng_set), .eng_clr(eng_clr),
        .seq_err(seq_err), .clr_cmd(clr_cmd), .ce_n(ce_n), .oe_n(oe_n),
        .dout(dout)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: dout actual %04h expected %04h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        bit rd_now;
        @(posedge clk);
        rd_now = !ce_n && !oe_n;
        if (rst) begin
            m_st = 8'h80; m_snap = 8'h80; m_rd = 0;
        end else begin
            if (rd_now && !m_rd) m_snap = m_st;
            m_rd = rd_now;
            m_st = m_st & ~(eng_clr & 8'hC4);
            if (clr_cmd) m_st = m_st & ~8'h3A;
            m_st = m_st | (eng_set & 8'hFE);
            if (seq_err) m_st = m_st | 8'h3A;
        end
        #2;
        check(tag, int'(dout), m_rd ? m_snap : 0);
        eng_set = '0; eng_clr = '0; seq_err = 0; clr_cmd = 0;
    endtask

    task automatic rd_byte(input string tag, input int exp);
        ce_n = 0; oe_n = 0;
        step(tag);
        check(tag, int'(dout), exp);
        ce_n = 1; oe_n = 1;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step("R1 reset");
        step("R1 reset");
        rst = 0;
        step("R9 idle");
        rd_byte("R1 reset value", 8'h80);

        eng_set = 8'h01; step("R2");
        rd_byte("R2 bit0 ignored", 8'h80);

        eng_clr = 8'h80; step("R3");
        rd_byte("R3 ready clear", 8'h00);
        eng_set = 8'h90; step("R1");
        rd_byte("R1 prog err map", 8'h90);
        eng_clr = 8'hFF; step("R3");
        rd_byte("R3 engine cannot clear errors", 8'h10);

        eng_set = 8'h20; step("R4");
        eng_set = 8'h08; step("R4");
        rd_byte("R4 accumulate", 8'h38);

        clr_cmd = 1; step("R5");
        rd_byte("R5 clear errors", 8'h00);
        eng_set = 8'hC4; step("R5");
        clr_cmd = 1; step("R5");
        rd_byte("R5 progress kept", 8'hC4);

        clr_cmd = 1; eng_set = 8'h02; step("R6");
        rd_byte("R6 set beats clear cmd", 8'hC6);
        eng_clr = 8'h40; eng_set = 8'h40; step("R6");
        rd_byte("R6 set beats engine clear", 8'hC6);
        eng_clr = 8'hC4; clr_cmd = 1; step("R5");
        rd_byte("R5 all clear", 8'h00);

        seq_err = 1; step("R7");
        rd_byte("R7 sequence error", 8'h3A);
        clr_cmd = 1; eng_set = 8'h80; step("R5");

        oe_n = 0; step("R9 ce high");
        check("R9 ce high", int'(dout), 0);
        ce_n = 0; step("R8 later fall");
        check("R8 capture", int'(dout), 8'h80);
        eng_set = 8'h10; step("R8 held");
        eng_set = 8'h04; step("R8 held");
        check("R10 no update while held", int'(dout), 8'h80);
        check("R9 upper byte", int'(dout) >> 8, 0);
        oe_n = 1; step("R9 oe high");
        check("R9 oe high", int'(dout), 0);
        oe_n = 0; step("R10 toggle");
        check("R10 new value", int'(dout), 8'h94);
        ce_n = 1; oe_n = 1; step("R9");

        rst = 1; step("R1 reset");
        rst = 0; step("R1");
        rd_byte("R1 reset again", 8'h80);

        for (int k = 0; k < 4; k++) step("R9 idle");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule